// File: doc/BRIEF.md
# Parity-Checked Reversible Full Adder

This block adds two bits and a carry using only two cascaded four-line reversible cells. Each cell is a one-through permutation of four bits in which the XOR of the outputs always equals the XOR of the inputs. Two extra lines enter the first cell tied to zero. The three lines that carry no arithmetic result are brought out as garbage outputs, so the circuit keeps as many output lines as it has input lines.

A checker XORs the five lines that enter the circuit (the three operands and the two zero constants). It XORs the five lines that leave it (sum, carry and the three garbage lines) and flags any difference. A fault-injection mask can invert any internal line, so a single corrupted wire is seen to reach the parity flag. All outputs, including the flag, are registered and appear one clock after the operands.

Each cell maps (A,B,C,D) to (A, A^B, C^(A&B), D^(A&~B)). The first cell takes (a, b, 0, 0). The second takes A = first cell's second output, B = carry-in, C = first cell's third output and D = first cell's fourth output. The second cell's second and third outputs are the sum and the carry.

Top module: `rpa_adder`

## Requirements
- R1: With `rst` high at a rising clock edge, all outputs (`sum_o`, `cout_o`, `junk_o`, `perr_o`) are 0 after that edge.
- R2: With `fault_i` zero, `sum_o` equals a^b^cin of the operands sampled at the previous rising edge.
- R3: With `fault_i` zero, `cout_o` equals the majority of a, b and cin sampled at the previous rising edge.
- R4: With `fault_i` zero, `junk_o[0]` = a, `junk_o[1]` = a^b and `junk_o[2]` = (a&~b)^((a^b)&~cin), all sampled at the previous edge.
- R5: With `fault_i` zero, `perr_o` is 0 for every operand combination.
- R6: Setting exactly one bit of `fault_i` inverts one internal line and makes `perr_o` 1 on the next cycle, for every one of the 13 lines and every operand combination. Bit index: 0 a, 1 b, 2 first zero constant, 3 second zero constant, 4 cin, 5 to 8 the four outputs of the first cell, and 9 to 12 the four outputs of the second cell.
- R7: With exactly two bits of `fault_i` set, `perr_o` is 0, so an even count of flipped lines goes undetected.
- R8: A fault on bit 10 (the sum line) inverts `sum_o` and leaves `cout_o` and `junk_o` at their fault-free values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | 1 | Operand a |
| b_i | input | 1 | Operand b |
| cin_i | input | 1 | Carry in |
| fault_i | input | 13 | Per-line inversion mask, index as in R6 |
| sum_o | output | 1 | Registered sum |
| cout_o | output | 1 | Registered carry out |
| junk_o | output | 3 | Registered garbage lines |
| perr_o | output | 1 | Registered parity-mismatch flag |

## Verification
All eight operand patterns are applied with no fault. This separates sum from carry and shows that each garbage line follows its own formula rather than a copy of an operand. Every single-line fault is then paired with every operand pattern. This shows that detection holds no matter which line breaks or what value it carried. Pairs of faults show the flag tracks the count of flips rather than their presence. A fault on the sum line alone shows that corruption stays confined to the line that was hit.

// File: rtl/rpa_pkg.sv
package rpa_pkg;
  localparam int CELL_W  = 4;
  localparam int N_CELLS = 2;
  localparam int N_OPER  = 3;
  localparam int N_CONST = 2;
  localparam int N_SRC   = N_OPER + N_CONST;
  localparam int N_NETS  = N_SRC + N_CELLS * CELL_W;
  localparam int N_GARB  = N_SRC - 2;
  localparam int N_OUT   = N_GARB + 2;

  // Line indices into the fault mask
  localparam int L_SRC0  = 0;
  localparam int L_C1    = N_SRC;
  localparam int L_C2    = N_SRC + CELL_W;
  localparam int L_SUM   = L_C2 + 1;

  function automatic logic [CELL_W-1:0] cell_map(input logic [CELL_W-1:0] v);
    logic [CELL_W-1:0] r;
    r[0] = v[0];
    r[1] = v[0] ^ v[1];
    r[2] = v[2] ^ (v[0] & v[1]);
    r[3] = v[3] ^ (v[0] & ~v[1]);
    return r;
  endfunction
endpackage

// File: rtl/rpa_gate_cell.sv
module rpa_gate_cell
  import rpa_pkg::*;
(
  input  logic [CELL_W-1:0] in_v,
  output logic [CELL_W-1:0] out_v
);
  always_comb out_v = cell_map(in_v);
endmodule

// File: rtl/rpa_fault_tap.sv
module rpa_fault_tap #(
  parameter int W = 4
) (
  input  logic [W-1:0] clean_v,
  input  logic [W-1:0] flip_v,
  output logic [W-1:0] line_v
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign line_v[i] = clean_v[i] ^ flip_v[i];
  end
endmodule

// File: rtl/rpa_parity_cmp.sv
module rpa_parity_cmp #(
  parameter int IW = 5,
  parameter int OW = 5
) (
  input  logic [IW-1:0] src_v,
  input  logic [OW-1:0] dst_v,
  output logic          diff
);
  assign diff = (^src_v) ^ (^dst_v);
endmodule

// File: rtl/rpa_adder.sv
module rpa_adder
  import rpa_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              a_i,
  input  logic              b_i,
  input  logic              cin_i,
  input  logic [N_NETS-1:0] fault_i,
  output logic              sum_o,
  output logic              cout_o,
  output logic [N_GARB-1:0] junk_o,
  output logic              perr_o
);
  logic [N_SRC-1:0]  src_raw, src_ln;
  logic [CELL_W-1:0] c1_in, c1_raw, c1_ln;
  logic [CELL_W-1:0] c2_in, c2_raw, c2_ln;
  logic [N_OUT-1:0]  out_v;
  logic              mismatch;

  // source lines: a, b, zero, zero, cin
  assign src_raw = {cin_i, {N_CONST{1'b0}}, b_i, a_i};

  rpa_fault_tap #(.W(N_SRC)) u_tap_src (
    .clean_v(src_raw), .flip_v(fault_i[L_SRC0 +: N_SRC]), .line_v(src_ln));

  assign c1_in = src_ln[CELL_W-1:0];

  rpa_gate_cell u_cell1 (.in_v(c1_in), .out_v(c1_raw));

  rpa_fault_tap #(.W(CELL_W)) u_tap_c1 (
    .clean_v(c1_raw), .flip_v(fault_i[L_C1 +: CELL_W]), .line_v(c1_ln));

  // second cell: A=a^b, B=cin, C=a&b, D=a&~b
  assign c2_in = {c1_ln[3], c1_ln[2], src_ln[N_SRC-1], c1_ln[1]};

  rpa_gate_cell u_cell2 (.in_v(c2_in), .out_v(c2_raw));

  rpa_fault_tap #(.W(CELL_W)) u_tap_c2 (
    .clean_v(c2_raw), .flip_v(fault_i[L_C2 +: CELL_W]), .line_v(c2_ln));

  assign out_v = {c2_ln, c1_ln[0]};

  rpa_parity_cmp #(.IW(N_SRC), .OW(N_OUT)) u_par (
    .src_v(src_raw), .dst_v(out_v), .diff(mismatch));

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o  <= 1'b0;
      cout_o <= 1'b0;
      junk_o <= '0;
      perr_o <= 1'b0;
    end else begin
      sum_o  <= c2_ln[1];
      cout_o <= c2_ln[2];
      junk_o <= {c2_ln[3], c2_ln[0], c1_ln[0]};
      perr_o <= mismatch;
    end
  end
endmodule

// File: rtl/rpa_adder_chk.sv
module rpa_adder_chk
  import rpa_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              a_i,
  input logic              b_i,
  input logic              cin_i,
  input logic [N_NETS-1:0] fault_i,
  input logic              sum_o,
  input logic              cout_o,
  input logic [N_GARB-1:0] junk_o,
  input logic              perr_o
);
  localparam logic [N_NETS-1:0] SUM_ONLY = N_NETS'(1) << L_SUM;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!sum_o && !cout_o && junk_o == '0 && !perr_o));

  assert_sum_R2: assert property (@(posedge clk) disable iff (rst)
    (fault_i == '0) |=> (sum_o == ($past(a_i) ^ $past(b_i) ^ $past(cin_i))));

  assert_carry_R3: assert property (@(posedge clk) disable iff (rst)
    (fault_i == '0) |=> (cout_o == (($past(a_i) && $past(b_i)) ||
                                    ($past(cin_i) && ($past(a_i) || $past(b_i))))));

  assert_junk_a_R4: assert property (@(posedge clk) disable iff (rst)
    (fault_i == '0) |=> (junk_o[0] == $past(a_i)));

  assert_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (fault_i == '0) |=> !perr_o);

  assert_single_flag_R6: assert property (@(posedge clk) disable iff (rst)
    ($countones(fault_i) == 1) |=> perr_o);

  assert_pair_blind_R7: assert property (@(posedge clk) disable iff (rst)
    ($countones(fault_i) == 2) |=> !perr_o);

  assert_sum_flip_R8: assert property (@(posedge clk) disable iff (rst)
    (fault_i == SUM_ONLY) |=> (sum_o != ($past(a_i) ^ $past(b_i) ^ $past(cin_i))));
endmodule

bind rpa_adder rpa_adder_chk u_chk (
  .clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .fault_i(fault_i),
  .sum_o(sum_o), .cout_o(cout_o), .junk_o(junk_o), .perr_o(perr_o));

// File: tb/sim_rpa_adder.sv
`timescale 1ns/1ps
module sim_rpa_adder;
  localparam int NN = 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          a_i = 1'b0, b_i = 1'b0, cin_i = 1'b0;
  logic [NN-1:0] fault_i = '0;
  logic          sum_o, cout_o, perr_o;
  logic [2:0]    junk_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  rpa_adder u0 (
    .clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .fault_i(fault_i),
    .sum_o(sum_o), .cout_o(cout_o), .junk_o(junk_o), .perr_o(perr_o));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic a, input logic b, input logic c,
                       input logic [NN-1:0] f);
    @(negedge clk);
    a_i = a; b_i = b; cin_i = c; fault_i = f;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    apply(1'b1, 1'b1, 1'b1, 13'h0001);
    rst = 1'b1;
    @(posedge clk); #1;
    check("R1 sum", int'(sum_o), 0);
    check("R1 cout", int'(cout_o), 0);
    check("R1 junk", int'(junk_o), 0);
    check("R1 perr", int'(perr_o), 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_clean();
    for (int v = 0; v < 8; v++) begin
      logic a, b, c;
      a = v[0]; b = v[1]; c = v[2];
      apply(a, b, c, '0);
      check("R2 sum", int'(sum_o), (int'(a) + int'(b) + int'(c)) % 2);
      check("R3 cout", int'(cout_o), int'((int'(a) + int'(b) + int'(c)) >= 2));
      check("R4 junk0", int'(junk_o[0]), int'(a));
      check("R4 junk1", int'(junk_o[1]), int'(a != b));
      check("R4 junk2", int'(junk_o[2]), int'((a && !b) != ((a != b) && !c)));
      check("R5 perr", int'(perr_o), 0);
    end
  endtask

  task automatic t_single();
    for (int i = 0; i < NN; i++) begin
      for (int v = 0; v < 8; v++) begin
        apply(v[0], v[1], v[2], NN'(1) << i);
        check($sformatf("R6 line %0d", i), int'(perr_o), 1);
      end
    end
  endtask

  task automatic t_pairs();
    int k = 0;
    for (int i = 0; i < NN; i++) begin
      for (int j = i + 1; j < NN; j++) begin
        apply(k[0], k[1], k[2], (NN'(1) << i) | (NN'(1) << j));
        check($sformatf("R7 lines %0d,%0d", i, j), int'(perr_o), 0);
        k++;
      end
    end
  endtask

  task automatic t_sum_line();
    for (int v = 0; v < 8; v++) begin
      logic a, b, c;
      a = v[0]; b = v[1]; c = v[2];
      apply(a, b, c, NN'(1) << 10);
      check("R8 sum", int'(sum_o), 1 - (int'(a) + int'(b) + int'(c)) % 2);
      check("R8 cout", int'(cout_o), int'((int'(a) + int'(b) + int'(c)) >= 2));
      check("R8 junk1", int'(junk_o[1]), int'(a != b));
      check("R8 junk2", int'(junk_o[2]), int'((a && !b) != ((a != b) && !c)));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_clean();
    t_single();
    t_pairs();
    t_sum_line();
    t_reset();
    t_clean();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule